// File: doc/BRIEF.md
# Ordered Audio Control-Change Sequencer

This block sits between a control plane and an external register bank that holds three byte-wide control registers: a system register, a monitor-routing register and a clock/configuration register. Control requests arrive as a kind plus a small argument. The kinds are mute, phantom power and the input 1/2 mode. The block translates each request into the ordered write, or pair of writes, that the analog hardware needs. Each write goes out through a request/acknowledge port, one at a time.

Two of these controls touch a pair of dependent bits. The order in which those bits change protects the attached circuits, and it flips with the direction of the change. The block therefore plans both writes from a shadow copy of the system register and issues them strictly in sequence. A request that would leave the register unchanged causes no traffic at all.

Coming out of reset, the block runs its own power-up sequence. A mute change also raises a one-cycle side pulse, so that a downstream agent can apply the matching converter soft-mute.

Top module: `qs_ctrl_seq`

## Requirements
- R1: Synchronous reset leaves `busy` high and starts four writes in this order: system register (select 0) = 0x08, system = 0x88, monitor register (select 1) = 0x00, configuration register (select 2) = 0x00. After the fourth acknowledge, `busy` falls.
- R2: A write holds `wr_req`, `wr_sel` and `wr_data` steady until `wr_ack` is seen high at a clock edge. The next write of a sequence starts only after that edge. A shadow register changes only on the edge where its write is acknowledged.
- R3: Phantom on (`req_kind`=1, `req_arg[0]`=1) issues two system writes. The first sets bit 1 (supply voltage). The second then clears bit 3 (phantom disable, active low).
- R4: Phantom off (`req_kind`=1, `req_arg[0]`=0) first clears bit 1, then sets bit 3, as two system writes.
- R5: Mic mode (`req_kind`=2, `req_arg`=1) and low-cut mode (`req_arg`=2 or 3) each issue two system writes. The first sets bit 0 (relay). The second sets bits [5:4] to 01 for mic or 11 for low-cut.
- R6: Line mode (`req_kind`=2, `req_arg`=0) first clears bits [5:4] to 00, then clears bit 0, as two system writes.
- R7: The select field in bits [5:4] of any system write is never 10. Argument codes 2 and 3 both select 11.
- R8: A mute change (`req_kind`=0, `req_arg[0]`=1 mutes) issues one system write with bit 2 equal to the request. In the same cycle as the first `wr_req` of that change, `smute_valid` pulses for one cycle with `smute_val` equal to bit 2.
- R9: A request whose target state equals the current shadow state issues no write, raises no `smute_valid` and leaves `busy` low. `req_kind`=3 is also ignored.
- R10: Requests presented while `busy` is high are ignored and leave no effect after the sequence ends.
- R11: `sys_q`, `mon_q` and `cfg_q` show the acknowledged contents of the three registers. After reset they are 0x08, 0x00 and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_kind | input | 2 | 0 mute, 1 phantom, 2 input mode, 3 none |
| req_arg | input | 2 | Request argument (see R3 to R8) |
| busy | output | 1 | A write sequence is in progress |
| wr_req | output | 1 | Register write request |
| wr_sel | output | 2 | Target register: 0 system, 1 monitor, 2 configuration |
| wr_data | output | 8 | Value to write |
| wr_ack | input | 1 | Write accepted by the register bank |
| sys_q | output | 8 | Shadow of the system register |
| mon_q | output | 8 | Shadow of the monitor register |
| cfg_q | output | 8 | Shadow of the configuration register |
| smute_valid | output | 1 | One-cycle converter soft-mute request |
| smute_val | output | 1 | Soft-mute polarity, 1 = mute |

## Verification
A corrupted shadow shows up on `sys_q` at once. It also appears at the next request, either as a wrong first write value or as a request wrongly suppressed or wrongly issued. A broken step index or count shows up within one acknowledge as a repeated write, a missing write or an early fall of `busy`. The tests therefore log every acknowledged write with its select and data and compare the whole ordered list for each direction of each control. They repeat requests to expose false suppression, and they slow the acknowledge to show that shadows and outputs wait for it.

// File: rtl/qs_pkg.sv
package qs_pkg;
  typedef enum logic [1:0] {
    K_MUTE    = 2'd0,
    K_PHANTOM = 2'd1,
    K_INPUT   = 2'd2,
    K_NONE    = 2'd3
  } req_kind_e;

  localparam int REG_SYS = 0;
  localparam int REG_MON = 1;
  localparam int REG_CFG = 2;

  // system register bit positions
  localparam int B_RELAY = 0;
  localparam int B_VOLT  = 1;
  localparam int B_MUTE  = 2;
  localparam int B_PHN   = 3;
  localparam int B_SEL_L = 4;
  localparam int B_SEL_H = 5;
  localparam int B_PWR   = 7;
endpackage

// File: rtl/qs_planner.sv
module qs_planner
  import qs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        kind,
  input  logic [1:0]        arg,
  input  logic [DATA_W-1:0] sys_cur,
  output logic [1:0]        n_steps,
  output logic [DATA_W-1:0] d0,
  output logic [DATA_W-1:0] d1,
  output logic              smute_fire,
  output logic              smute_pol
);
  logic [1:0] sel_tgt;

  always_comb begin
    n_steps    = 2'd0;
    d0         = sys_cur;
    d1         = sys_cur;
    smute_fire = 1'b0;
    smute_pol  = arg[0];
    sel_tgt    = (arg == 2'd0) ? 2'b00 : (arg == 2'd1) ? 2'b01 : 2'b11;
    case (req_kind_e'(kind))
      K_MUTE: begin
        if (sys_cur[B_MUTE] != arg[0]) begin
          n_steps      = 2'd1;
          d0[B_MUTE]   = arg[0];
          smute_fire   = 1'b1;
        end
      end
      K_PHANTOM: begin
        if (arg[0] && !sys_cur[B_VOLT]) begin
          n_steps    = 2'd2;
          d0[B_VOLT] = 1'b1;
          d1         = d0;
          d1[B_PHN]  = 1'b0;
        end else if (!arg[0] && sys_cur[B_VOLT]) begin
          n_steps    = 2'd2;
          d0[B_VOLT] = 1'b0;
          d1         = d0;
          d1[B_PHN]  = 1'b1;
        end
      end
      K_INPUT: begin
        if (sel_tgt != sys_cur[B_SEL_H:B_SEL_L]) begin
          n_steps = 2'd2;
          if (sel_tgt == 2'b00) begin
            d0[B_SEL_H:B_SEL_L] = 2'b00;
            d1                  = d0;
            d1[B_RELAY]         = 1'b0;
          end else begin
            d0[B_RELAY]         = 1'b1;
            d1                  = d0;
            d1[B_SEL_H:B_SEL_L] = sel_tgt;
          end
        end
      end
      default: n_steps = 2'd0;
    endcase
  end
endmodule

// File: rtl/qs_shadow.sv
module qs_shadow
  import qs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_REGS = 3,
  parameter logic [DATA_W-1:0] SYS_RST = 8'h08
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_fire,
  input  logic [$clog2(N_REGS)-1:0] wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         regs [N_REGS]
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = (g == REG_SYS) ? SYS_RST : '0;
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= RV;
      else if (wr_fire && wr_sel == g) regs[g] <= wr_data;
    end

    a_r2_shadow_on_ack: assert property (@(posedge clk) disable iff (rst)
      !(wr_fire && wr_sel == g) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/qs_ctrl_seq.sv
module qs_ctrl_seq
  import qs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_REGS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_arg,
  output logic              busy,
  output logic              wr_req,
  output logic [1:0]        wr_sel,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic [DATA_W-1:0] sys_q,
  output logic [DATA_W-1:0] mon_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic              smute_valid,
  output logic              smute_val
);
  localparam int SEL_W = $clog2(N_REGS);
  localparam int STEPS = 4;
  localparam int IDX_W = $clog2(STEPS);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [DATA_W-1:0] SYS_A = DATA_W'(1) << B_PHN;
  localparam logic [DATA_W-1:0] SYS_B = SYS_A | (DATA_W'(1) << B_PWR);

  logic [SEL_W-1:0]  st_sel  [STEPS];
  logic [DATA_W-1:0] st_data [STEPS];
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_nx;
  logic [CNT_W-1:0]  cnt;
  logic              req_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] data_q;
  logic              sm_v_q, sm_p_q;
  logic [DATA_W-1:0] regs [N_REGS];

  logic [1:0]        p_n;
  logic [DATA_W-1:0] p_d0, p_d1;
  logic              p_sm, p_pol;

  qs_planner #(.DATA_W(DATA_W)) i_plan (
    .kind(req_kind), .arg(req_arg), .sys_cur(regs[REG_SYS]),
    .n_steps(p_n), .d0(p_d0), .d1(p_d1),
    .smute_fire(p_sm), .smute_pol(p_pol)
  );

  qs_shadow #(.DATA_W(DATA_W), .N_REGS(N_REGS), .SYS_RST(SYS_A)) i_shadow (
    .clk(clk), .rst(rst), .wr_fire(req_q && wr_ack),
    .wr_sel(sel_q), .wr_data(data_q), .regs(regs)
  );

  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_sel[0]  <= SEL_W'(REG_SYS); st_data[0] <= SYS_A;
      st_sel[1]  <= SEL_W'(REG_SYS); st_data[1] <= SYS_B;
      st_sel[2]  <= SEL_W'(REG_MON); st_data[2] <= '0;
      st_sel[3]  <= SEL_W'(REG_CFG); st_data[3] <= '0;
      cnt    <= CNT_W'(STEPS);
      idx    <= '0;
      req_q  <= 1'b1;
      sel_q  <= SEL_W'(REG_SYS);
      data_q <= SYS_A;
      sm_v_q <= 1'b0;
      sm_p_q <= 1'b0;
    end else begin
      sm_v_q <= 1'b0;
      if (req_q) begin
        if (wr_ack) begin
          if ({1'b0, idx} + 1'b1 == cnt) begin
            req_q <= 1'b0;
          end else begin
            idx    <= idx_nx;
            sel_q  <= st_sel[idx_nx];
            data_q <= st_data[idx_nx];
          end
        end
      end else if (req_valid && p_n != 2'd0) begin
        st_sel[0]  <= SEL_W'(REG_SYS); st_data[0] <= p_d0;
        st_sel[1]  <= SEL_W'(REG_SYS); st_data[1] <= p_d1;
        cnt    <= CNT_W'(p_n);
        idx    <= '0;
        req_q  <= 1'b1;
        sel_q  <= SEL_W'(REG_SYS);
        data_q <= p_d0;
        sm_v_q <= p_sm;
        sm_p_q <= p_pol;
      end
    end
  end

  assign busy        = req_q;
  assign wr_req      = req_q;
  assign wr_sel      = 2'(sel_q);
  assign wr_data     = data_q;
  assign sys_q       = regs[REG_SYS];
  assign mon_q       = regs[REG_MON];
  assign cfg_q       = regs[REG_CFG];
  assign smute_valid = sm_v_q;
  assign smute_val   = sm_p_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req && $stable(wr_sel) && $stable(wr_data));
  a_r2_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_req) |-> $past(wr_ack));
  a_r7_no_rsvd_sel: assert property (@(posedge clk) disable iff (rst)
    wr_req && wr_sel == 2'(REG_SYS) |-> wr_data[B_SEL_H:B_SEL_L] != 2'b10);
  a_r5_relay_before_sel: assert property (@(posedge clk) disable iff (rst)
    sys_q[B_SEL_H:B_SEL_L] != 2'b00 |-> sys_q[B_RELAY]);
  a_r8_smute_match: assert property (@(posedge clk) disable iff (rst)
    smute_valid |-> wr_req && wr_sel == 2'(REG_SYS) && wr_data[B_MUTE] == smute_val);
endmodule

// File: tb/test_qs_ctrl_seq.sv
module test_qs_ctrl_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic [1:0] req_arg = 2'd0;
  logic       busy, wr_req, wr_ack = 1'b0;
  logic [1:0] wr_sel;
  logic [7:0] wr_data, sys_q, mon_q, cfg_q;
  logic       smute_valid, smute_val;

  int n_chk = 0, n_fail = 0;
  int ack_lat = 0, wait_cnt = 0;
  bit ack_en = 1'b0;
  int nlog = 0;
  logic [1:0] log_sel [16];
  logic [7:0] log_dat [16];
  int sm_cnt = 0;
  logic sm_last = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  qs_ctrl_seq i_qs_ctrl_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_arg(req_arg), .busy(busy), .wr_req(wr_req), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_ack(wr_ack), .sys_q(sys_q), .mon_q(mon_q),
    .cfg_q(cfg_q), .smute_valid(smute_valid), .smute_val(smute_val)
  );

  // register bank model
  initial forever begin
    @(negedge clk);
    if (wr_ack) begin
      wr_ack = 1'b0;
      wait_cnt = 0;
    end else if (wr_req && ack_en) begin
      if (wait_cnt >= ack_lat) begin
        wr_ack = 1'b1;
        if (nlog < 16) begin
          log_sel[nlog] = wr_sel;
          log_dat[nlog] = wr_data;
        end
        nlog++;
      end else wait_cnt++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (smute_valid) begin sm_cnt++; sm_last = smute_val; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_arg = a;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd3;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_pair(input string tag, input logic [7:0] a, input logic [7:0] b, input logic [7:0] fin);
    chk({tag, " write count"}, nlog, 2);
    chk({tag, " first write"}, {log_sel[0], log_dat[0]}, {2'd0, a});
    chk({tag, " second write"}, {log_sel[1], log_dat[1]}, {2'd0, b});
    chk({tag, " shadow"}, sys_q, fin);
  endtask

  task automatic t_reset_init();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1);
    chk("R1 first write pending", {wr_req, wr_sel, wr_data}, {1'b1, 2'd0, 8'h08});
    chk("R11 reset shadows", {sys_q, mon_q, cfg_q}, {8'h08, 8'h00, 8'h00});
    nlog = 0;
    ack_en = 1'b1;
    wait_idle();
    chk("R1 init write count", nlog, 4);
    chk("R1 init w0", {log_sel[0], log_dat[0]}, {2'd0, 8'h08});
    chk("R1 init w1", {log_sel[1], log_dat[1]}, {2'd0, 8'h88});
    chk("R1 init w2", {log_sel[2], log_dat[2]}, {2'd1, 8'h00});
    chk("R1 init w3", {log_sel[3], log_dat[3]}, {2'd2, 8'h00});
    chk("R11 shadows after init", {sys_q, mon_q, cfg_q}, {8'h88, 8'h00, 8'h00});
  endtask

  task automatic t_phantom();
    nlog = 0; issue(2'd1, 2'd1); wait_idle();
    chk_pair("R3 phantom on", 8'h8A, 8'h82, 8'h82);
    nlog = 0; issue(2'd1, 2'd1); wait_idle();
    chk("R9 repeated phantom on writes", nlog, 0);
    nlog = 0; issue(2'd1, 2'd0); wait_idle();
    chk_pair("R4 phantom off", 8'h80, 8'h88, 8'h88);
  endtask

  task automatic t_input();
    nlog = 0; issue(2'd2, 2'd1); wait_idle();
    chk_pair("R5 mic", 8'h89, 8'h99, 8'h99);
    nlog = 0; issue(2'd2, 2'd2); wait_idle();
    chk_pair("R7 low-cut code2", 8'h99, 8'hB9, 8'hB9);
    nlog = 0; issue(2'd2, 2'd3); wait_idle();
    chk("R7 code3 equals code2, no write", nlog, 0);
    nlog = 0; issue(2'd2, 2'd0); wait_idle();
    chk_pair("R6 line", 8'h89, 8'h88, 8'h88);
    nlog = 0; issue(2'd2, 2'd3); wait_idle();
    chk_pair("R5 low-cut code3 from line", 8'h89, 8'hB9, 8'hB9);
    nlog = 0; issue(2'd2, 2'd0); wait_idle();
    chk_pair("R6 line from low-cut", 8'h89, 8'h88, 8'h88);
  endtask

  task automatic t_mute();
    nlog = 0; sm_cnt = 0; issue(2'd0, 2'd1); wait_idle();
    chk("R8 mute write count", nlog, 1);
    chk("R8 mute write", {log_sel[0], log_dat[0]}, {2'd0, 8'h8C});
    chk("R8 smute pulse", {sm_cnt[7:0], 7'd0, sm_last}, {8'd1, 8'd1});
    nlog = 0; sm_cnt = 0; issue(2'd0, 2'd1); wait_idle();
    chk("R9 repeated mute no write/pulse", {nlog[7:0], sm_cnt[7:0], 7'd0, busy}, 24'd0);
    nlog = 0; sm_cnt = 0; issue(2'd0, 2'd0); wait_idle();
    chk("R8 unmute write", {nlog[7:0], log_dat[0]}, {8'd1, 8'h88});
    chk("R8 unmute smute pulse", {sm_cnt[7:0], 7'd0, sm_last}, {8'd1, 8'd0});
    nlog = 0; issue(2'd3, 2'd1); wait_idle();
    chk("R9 kind 3 ignored", {nlog[7:0], sys_q}, {8'd0, 8'h88});
  endtask

  task automatic t_busy();
    ack_lat = 5; nlog = 0; sm_cnt = 0;
    issue(2'd1, 2'd1);
    chk("R2 shadow waits for ack", {busy, sys_q}, {1'b1, 8'h88});
    issue(2'd0, 2'd1);
    chk("R2 data held while unacked", {wr_req, wr_data}, {1'b1, 8'h8A});
    wait_idle();
    chk_pair("R10 phantom during slow ack", 8'h8A, 8'h82, 8'h82);
    chk("R10 mute while busy ignored", {sm_cnt[7:0], 7'd0, sys_q[2]}, 16'd0);
    chk("R11 other shadows untouched", {mon_q, cfg_q}, 16'd0);
    ack_lat = 0;
  endtask

  initial begin
    t_reset_init();
    t_phantom();
    t_input();
    t_mute();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule